// File: doc/BRIEF.md
# Busy-Count Handshake Monitor

This block watches a request/busy/done handshake at run time and judges each transaction. A request opens a window. From the next cycle on, the monitor counts every cycle in which busy is high. These cycles do not have to be adjacent: idle cycles may fall between them, and also between the last busy cycle and done. When done arrives, the monitor compares the count with an inclusive range set by two parameters and gives a one-cycle pass or error pulse.

Setting the minimum equal to the maximum makes the check demand an exact number of busy cycles. A wider range accepts a spread of counts. The monitor also gives an error as soon as the count goes past the maximum. It treats a second request inside an open window as an error and starts a new window from that request. Both result outputs are registered.

Top module: `busy_window_monitor`

## Requirements
- R1: A synchronous active-high reset sets the monitor to idle with a zero count, and holds both passPulse and errPulse low in the cycle after the reset edge.
- R2: When the monitor is idle and req is sampled high, a window opens with a count of zero. The busy value sampled in that same req cycle is not counted.
- R3: While a window is open and neither req nor done is high, each cycle with busy high adds one to the count, whether or not it follows another busy cycle. Busy sampled in the done cycle is not counted.
- R4: When done is sampled high in an open window and the count lies between MIN_BUSY and MAX_BUSY inclusive, passPulse is high for exactly the next cycle and the monitor returns to idle.
- R5: When done is sampled high in an open window and the count is below MIN_BUSY, errPulse is high for exactly the next cycle and the monitor returns to idle.
- R6: The busy cycle that takes the count from MAX_BUSY to MAX_BUSY+1 gives one errPulse in the next cycle. The window stays open and the count saturates at MAX_BUSY+1 with no further overshoot pulses. A later done then gives errPulse.
- R7: When req is sampled high in an open window, errPulse is high for the next cycle and the window restarts with a count of zero. This takes priority over done and busy in the same cycle.
- R8: While the monitor is idle, busy and done have no effect: no pulse appears and the monitor stays idle.
- R9: passPulse and errPulse are never high in the same cycle.
- R10: With req in cycle 1, busy in cycles 2, 4 and 6, done in cycle 8, and all inputs low otherwise over cycles 0 to 9, the monitor passes with MIN_BUSY=MAX_BUSY=3 and also with MIN_BUSY=2, MAX_BUSY=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Opens or restarts a check window |
| busy | input | 1 | Busy indication, counted while a window is open |
| done | input | 1 | Closes the window and triggers the range check |
| passPulse | output | 1 | One-cycle pulse for a window that closed in range |
| errPulse | output | 1 | One-cycle pulse for a protocol or count error |

## Verification
The overshoot case is the hardest to reach from the ports. It needs more than MAX_BUSY busy cycles with no req and no done in between, and random traffic rarely gives that. Directed sequences therefore drive long busy runs with gaps, then a late done, and check the single overshoot pulse and the error at close. The bench runs two instances side by side, one set to an exact count and one set to a range, so that each stimulus exercises both the exact bound and the range bound.

// File: rtl/busy_window_pkg.sv
package busy_window_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } winState_t;

  // strobes sent from the control to the count datapath
  typedef struct packed {
    logic clear;
    logic inc;
  } cntStrobe_t;

endpackage

// File: rtl/busy_count_path.sv
module busy_count_path
  import busy_window_pkg::*;
#(
  parameter int MIN_BUSY = 2,
  parameter int MAX_BUSY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  cntStrobe_t strobe,
  output logic       inRange,
  output logic       atMax
);

  localparam int CNT_W = $clog2(MAX_BUSY + 2);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_BUSY);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(MAX_BUSY + 1);

  logic [CNT_W-1:0] cntQ;
  logic             geMin;
  logic             leMax;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (strobe.clear) begin
      cntQ <= '0;
    end else if (strobe.inc && (cntQ != SAT_V)) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  generate
    if (MIN_BUSY == 0) begin : g_noMin
      assign geMin = 1'b1;
    end else begin : g_min
      localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_BUSY);
      assign geMin = (cntQ >= MIN_V);
    end
  endgenerate

  assign leMax   = (cntQ <= MAX_V);
  assign inRange = geMin && leMax;
  assign atMax   = (cntQ == MAX_V);

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cntQ <= SAT_V);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.inc && !strobe.clear) |=> $stable(cntQ));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (cntQ == '0));

endmodule

// File: rtl/busy_window_ctrl.sv
module busy_window_ctrl
  import busy_window_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       busy,
  input  logic       done,
  input  logic       inRange,
  input  logic       atMax,
  output cntStrobe_t strobe,
  output logic       passPulse,
  output logic       errPulse
);

  winState_t stateQ, stateD;
  logic      passD, errD;

  always_comb begin
    stateD       = stateQ;
    strobe.clear = 1'b0;
    strobe.inc   = 1'b0;
    passD        = 1'b0;
    errD         = 1'b0;
    unique case (stateQ)
      WIN_IDLE: begin
        if (req) begin
          strobe.clear = 1'b1;
          stateD       = WIN_OPEN;
        end
      end
      WIN_OPEN: begin
        if (req) begin
          errD         = 1'b1;
          strobe.clear = 1'b1;
        end else if (done) begin
          passD        = inRange;
          errD         = !inRange;
          strobe.clear = 1'b1;
          stateD       = WIN_IDLE;
        end else if (busy) begin
          strobe.inc = 1'b1;
          errD       = atMax;
        end
      end
      default: stateD = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= WIN_IDLE;
      passPulse <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      stateQ    <= stateD;
      passPulse <= passD;
      errPulse  <= errD;
    end
  end

  // R9
  one_outcome_chk: assert property (@(posedge clk)
    !(passPulse && errPulse));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!passPulse && !errPulse && stateQ == WIN_IDLE));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == WIN_IDLE && !req) |=> (!passPulse && !errPulse && stateQ == WIN_IDLE));

  // R7
  req_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == WIN_OPEN && req) |=> (errPulse && stateQ == WIN_OPEN));

  // R4
  pass_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(passPulse) |-> $past(done));

endmodule

// File: rtl/busy_window_monitor.sv
module busy_window_monitor
  import busy_window_pkg::*;
#(
  parameter int MIN_BUSY = 2,
  parameter int MAX_BUSY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic busy,
  input  logic done,
  output logic passPulse,
  output logic errPulse
);

  cntStrobe_t strobe;
  logic       inRange;
  logic       atMax;

  busy_window_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .busy     (busy),
    .done     (done),
    .inRange  (inRange),
    .atMax    (atMax),
    .strobe   (strobe),
    .passPulse(passPulse),
    .errPulse (errPulse)
  );

  busy_count_path #(
    .MIN_BUSY(MIN_BUSY),
    .MAX_BUSY(MAX_BUSY)
  ) u_path (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .inRange(inRange),
    .atMax  (atMax)
  );

  initial begin
    if (MIN_BUSY < 0 || MIN_BUSY > MAX_BUSY) $error("busy_window_monitor: bad bounds");
  end

endmodule

// File: tb/test_busy_window_monitor.sv
`timescale 1ns/1ps
module test_busy_window_monitor;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, busy = 1'b0, done = 1'b0;
  logic passA, errA, passB, errB;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // model state: A = range 2..4, B = exact 3
  bit openA = 0, openB = 0;
  int cntA = 0, cntB = 0;
  bit expPA, expEA, expPB, expEB;
  bit sawPA, sawPB;

  always #2.5 clk = ~clk;

  busy_window_monitor #(.MIN_BUSY(2), .MAX_BUSY(4)) i_busy_window_monitor (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .done(done),
    .passPulse(passA), .errPulse(errA)
  );

  busy_window_monitor #(.MIN_BUSY(3), .MAX_BUSY(3)) i_busy_window_monitor_fixed (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .done(done),
    .passPulse(passB), .errPulse(errB)
  );

  task automatic modelStep(input int mn, input int mx, input bit rs, input bit r,
                           input bit b, input bit d, inout bit op, inout int c,
                           output bit pp, output bit ep);
    pp = 0; ep = 0;
    if (rs) begin
      op = 0; c = 0;
    end else if (!op) begin
      if (r) begin op = 1; c = 0; end
    end else if (r) begin
      ep = 1; c = 0;
    end else if (d) begin
      if (c >= mn && c <= mx) pp = 1; else ep = 1;
      op = 0; c = 0;
    end else if (b) begin
      if (c == mx) ep = 1;
      if (c <= mx) c++;
    end
  endtask

  task automatic check(input bit act, input bit exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rs, input bit r, input bit b, input bit d);
    rst = rs; req = r; busy = b; done = d;
    @(posedge clk);
    modelStep(2, 4, rs, r, b, d, openA, cntA, expPA, expEA);
    modelStep(3, 3, rs, r, b, d, openB, cntB, expPB, expEB);
    #1;
    check(passA, expPA, "range pass");
    check(errA,  expEA, "range err");
    check(passB, expPB, "exact pass");
    check(errB,  expEB, "exact err");
    sawPA |= passA;
    sawPB |= passB;
  endtask

  initial begin
    void'($urandom(32'd4711));
    tag = "R1 reset";
    step(1, 0, 0, 0);
    step(1, 1, 1, 1);
    step(0, 0, 0, 0);

    // R10 reference trace, cycles 0..9
    tag = "R10 trace";
    sawPA = 0; sawPB = 0;
    step(0, 0, 0, 0); step(0, 1, 0, 0); step(0, 0, 1, 0); step(0, 0, 0, 0);
    step(0, 0, 1, 0); step(0, 0, 0, 0); step(0, 0, 1, 0); step(0, 0, 0, 0);
    step(0, 0, 0, 1); step(0, 0, 0, 0);
    check(sawPA, 1'b1, "R10 range config passed");
    check(sawPB, 1'b1, "R10 exact config passed");

    // R8 idle busy/done ignored
    tag = "R8 idle";
    step(0, 0, 1, 1); step(0, 0, 1, 0); step(0, 0, 0, 1);

    // R5 below minimum
    tag = "R5 below min";
    step(0, 1, 0, 0); step(0, 0, 1, 0); step(0, 0, 0, 0); step(0, 0, 0, 1); step(0, 0, 0, 0);

    // R6 overshoot, gaps included, then late done
    tag = "R6 overshoot";
    step(0, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1, 0);
      step(0, 0, 0, 0);
    end
    step(0, 0, 0, 1); step(0, 0, 0, 0);

    // R2 busy in req cycle not counted; R3 busy in done cycle not counted
    tag = "R2 R3 edges";
    step(0, 1, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 1); step(0, 0, 0, 0);

    // R7 req inside window, including req with done
    tag = "R7 restart";
    step(0, 1, 0, 0); step(0, 0, 1, 0); step(0, 1, 1, 0); step(0, 0, 1, 0);
    step(0, 0, 1, 0); step(0, 1, 0, 1); step(0, 0, 1, 0); step(0, 0, 1, 0);
    step(0, 0, 1, 0); step(0, 0, 0, 1); step(0, 0, 0, 0);

    // R1 reset in open window
    tag = "R1 mid reset";
    step(0, 1, 0, 0); step(0, 0, 1, 0); step(1, 0, 1, 0); step(0, 0, 0, 1); step(0, 0, 0, 0);

    // R3..R9 random traffic
    tag = "R4 R5 R6 R7 R9 random";
    for (int i = 0; i < 4000; i++) begin
      step(0, ($urandom % 14) == 0, $urandom % 2, ($urandom % 7) == 0);
      total++;
      if (passA && errA) begin bad++; $display("FAIL R9 both pulses actual=1 expected=0"); end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule